// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a sixteen-step trimmed resistor. A host sets the wiper position with three slow pins: an active-low select, a direction level and a step strobe that acts on its falling edge. While the block is selected, each falling edge of the strobe moves the position one tap up or down. The position stops at both ends and does not wrap. The position drives a one-hot tap-select vector, so exactly one switch of the resistor array is closed.

A shadow register stands in for the nonvolatile cell. The host chooses whether to keep a setting by the strobe level at the moment it releases select. If the strobe is high, the position is written to the shadow register and the block stays busy for a write window of `WRITE_CYCLES` clocks. If the strobe is low, the setting lasts only until the next power cycle. A power-cycle reset reloads the position from the shadow register. A factory reset sets both the position and the shadow register to mid-scale. After a write completes, the block reports standby until the host selects it again.

All three host pins are asynchronous. They pass through a two-flop synchroniser before edges are detected, so every host action appears at the outputs three clocks after the pin changes. Every port is a plain control or status pin. No data stream crosses the block's edge, so the block has no valid/ready handshake and no back-pressure.

Top module: `wiper_ctrl`

## Requirements
- R1: While `factory_rst_n` is low on a clock edge, the position and the stored value become mid-scale (tap 8 by default), `busy` becomes 0 and `standby` becomes 1.
- R2: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`.
- R3: With the block selected (`sel_n` low), a high-to-low change on `step_n` increments the position if `dir_up` is 1 and decrements it if `dir_up` is 0. The new position appears on the third rising clock edge after the pin change.
- R4: A step up at tap 15 or a step down at tap 0 leaves the position unchanged.
- R5: Falling edges of `step_n` while `sel_n` is high do not change the position.
- R6: A rising edge of `sel_n` with `step_n` high stores the current position and holds `busy` at 1 for exactly `WRITE_CYCLES` clocks.
- R7: A rising edge of `sel_n` with `step_n` low stores nothing. The position stays in effect, and the next power-cycle reset restores the previously stored value.
- R8: While `pwr_rst_n` is low on a clock edge (with `factory_rst_n` high), the position is loaded from the stored value. The stored value itself is kept.
- R9: While `busy` is 1, the block ignores the select and step pins: the position does not move and no further save starts.
- R10: `standby` is set by reset and in the clock where a write window ends. It clears once the block is selected while not busy.
- R11: `dir_up` may change while the block stays selected, so one selection can mix up and down steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| factory_rst_n | input | 1 | Synchronous active-low reset that also sets the stored value to mid-scale |
| pwr_rst_n | input | 1 | Synchronous active-low power-cycle reset that recalls the stored value |
| sel_n | input | 1 | Active-low select (asynchronous) |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down (asynchronous) |
| step_n | input | 1 | Step strobe, acts on its falling edge (asynchronous) |
| tap_sel | output | TAPS | One-hot tap switch enables |
| wiper_pos | output | PW | Current wiper position |
| busy | output | 1 | Write window in progress |
| standby | output | 1 | Low-power state after reset or a completed write |

## Verification
Only two internal states can go wrong here: the stored value and the write timer. A wrong live position shows on `wiper_pos` and `tap_sel` in the very clock it occurs. A wrong stored value stays hidden until the next power-cycle reset, and the bench cycles power after every save and every unsaved deselect to expose it. A write window that is too short or too long shows on `busy` and `standby` in the clock it ends. A save or step accepted during that window moves the position or extends `busy` within three clocks. The behavioural model is compared against all four outputs on every clock.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Host pins after synchronisation; field order is fixed by the pin vector.
  typedef struct packed {
    logic sel_n;
    logic step_n;
    logic dir_up;
  } host_pins_t;

  localparam host_pins_t PINS_IDLE = '{sel_n: 1'b1, step_n: 1'b1, dir_up: 1'b0};
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wiper_events.sv
module wiper_events
  import wiper_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  host_pins_t pins,
  input  logic       busy,
  output logic       step_evt,
  output logic       step_up,
  output logic       save_evt,
  output logic       sel_active
);
  logic prev_sel_n;
  logic prev_step_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel_n  <= PINS_IDLE.sel_n;
      prev_step_n <= PINS_IDLE.step_n;
    end else begin
      prev_sel_n  <= pins.sel_n;
      prev_step_n <= pins.step_n;
    end
  end

  logic step_fall, sel_rise;
  always_comb begin
    step_fall  = prev_step_n & ~pins.step_n;
    sel_rise   = pins.sel_n & ~prev_sel_n;
    sel_active = ~busy & ~pins.sel_n;
    step_evt   = sel_active & step_fall;
    step_up    = pins.dir_up;
    save_evt   = ~busy & sel_rise & pins.step_n;
  end

  // R5: no step is reported while deselected
  p_no_step_deselected_r5: assert property (@(posedge clk) disable iff (rst)
    pins.sel_n |-> !step_evt);
endmodule

// File: rtl/wiper_count.sv
module wiper_count #(
  parameter int TAPS        = 16,
  parameter int DEFAULT_TAP = TAPS / 2,
  localparam int PW         = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          factory_rst,
  input  logic          pwr_rst,
  input  logic [PW-1:0] stored,
  input  logic          step_evt,
  input  logic          step_up,
  input  logic          busy,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

  always_ff @(posedge clk) begin
    if (factory_rst)       pos <= PW'(DEFAULT_TAP);
    else if (pwr_rst)      pos <= stored;
    else if (step_evt) begin
      if (step_up && pos != TOP)       pos <= pos + 1'b1;
      else if (!step_up && pos != '0)  pos <= pos - 1'b1;
    end
  end

  // R4: saturate at the top
  p_sat_top_r4: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    (step_evt && step_up && pos == TOP) |=> pos == TOP);
  // R4: saturate at the bottom
  p_sat_bot_r4: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    (step_evt && !step_up && pos == '0) |=> pos == '0);
  // R3: an up step below the top moves exactly one tap
  p_step_up_r3: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    (step_evt && step_up && pos != TOP) |=> pos == $past(pos) + 1'b1);
  // R9: position frozen during a write window
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    busy |=> $stable(pos));
endmodule

// File: rtl/wiper_nvm.sv
module wiper_nvm #(
  parameter int TAPS         = 16,
  parameter int DEFAULT_TAP  = TAPS / 2,
  parameter int WRITE_CYCLES = 500000,
  localparam int PW          = $clog2(TAPS),
  localparam int CW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          factory_rst,
  input  logic          pwr_rst,
  input  logic          save_evt,
  input  logic          sel_active,
  input  logic [PW-1:0] pos,
  output logic [PW-1:0] stored,
  output logic          busy,
  output logic          standby
);
  logic [CW-1:0] wr_cnt;

  // Shadow of the nonvolatile cell: only the factory reset touches it.
  always_ff @(posedge clk) begin
    if (factory_rst)   stored <= PW'(DEFAULT_TAP);
    else if (save_evt) stored <= pos;
  end

  always_ff @(posedge clk) begin
    if (factory_rst || pwr_rst) begin
      wr_cnt  <= '0;
      standby <= 1'b1;
    end else begin
      if (save_evt)           wr_cnt <= CW'(WRITE_CYCLES);
      else if (wr_cnt != '0) wr_cnt <= wr_cnt - 1'b1;
      if (wr_cnt == CW'(1))  standby <= 1'b1;
      else if (sel_active)   standby <= 1'b0;
    end
  end

  assign busy = (wr_cnt != '0);

  // R6: a save opens the write window on the next clock
  p_save_busy_r6: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    save_evt |=> busy);
  // R10: standby is up when the write window closes
  p_standby_end_r10: assert property (@(posedge clk) disable iff (factory_rst || pwr_rst)
    $fell(busy) |-> standby);
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int TAPS = 16,
  localparam int PW  = $clog2(TAPS)
) (
  input  logic [PW-1:0]   pos,
  output logic [TAPS-1:0] tap_sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == PW'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int TAPS         = 16,
  parameter int DEFAULT_TAP  = TAPS / 2,
  parameter int WRITE_CYCLES = 500000,
  parameter int SYNC_STAGES  = 2,
  localparam int PW          = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            factory_rst_n,
  input  logic            pwr_rst_n,
  input  logic            sel_n,
  input  logic            dir_up,
  input  logic            step_n,
  output logic [TAPS-1:0] tap_sel,
  output logic [PW-1:0]   wiper_pos,
  output logic            busy,
  output logic            standby
);
  localparam int PINW = $bits(host_pins_t);

  logic factory_rst, pwr_rst, any_rst;
  assign factory_rst = ~factory_rst_n;
  assign pwr_rst     = ~pwr_rst_n;
  assign any_rst     = factory_rst | pwr_rst;

  host_pins_t raw_pins, sy_pins;
  logic [PINW-1:0] sy_vec;
  assign raw_pins = '{sel_n: sel_n, step_n: step_n, dir_up: dir_up};

  wiper_sync #(.W(PINW), .STAGES(SYNC_STAGES), .IDLE(PINS_IDLE)) u_sync (
    .clk(clk), .rst(any_rst), .d(raw_pins), .q(sy_vec)
  );
  assign sy_pins = host_pins_t'(sy_vec);

  logic step_evt, step_up, save_evt, sel_active;
  wiper_events u_evt (
    .clk(clk), .rst(any_rst), .pins(sy_pins), .busy(busy),
    .step_evt(step_evt), .step_up(step_up), .save_evt(save_evt), .sel_active(sel_active)
  );

  logic [PW-1:0] stored;
  wiper_count #(.TAPS(TAPS), .DEFAULT_TAP(DEFAULT_TAP)) u_cnt (
    .clk(clk), .factory_rst(factory_rst), .pwr_rst(pwr_rst), .stored(stored),
    .step_evt(step_evt), .step_up(step_up), .busy(busy), .pos(wiper_pos)
  );

  wiper_nvm #(.TAPS(TAPS), .DEFAULT_TAP(DEFAULT_TAP), .WRITE_CYCLES(WRITE_CYCLES)) u_nvm (
    .clk(clk), .factory_rst(factory_rst), .pwr_rst(pwr_rst), .save_evt(save_evt),
    .sel_active(sel_active), .pos(wiper_pos), .stored(stored), .busy(busy), .standby(standby)
  );

  wiper_decode #(.TAPS(TAPS)) u_dec (.pos(wiper_pos), .tap_sel(tap_sel));

  // R2: exactly one tap closed, at the reported position
  p_one_tap_r2: assert property (@(posedge clk) disable iff (any_rst)
    $countones(tap_sel) == 1 && tap_sel[wiper_pos]);
  // R8: power-cycle reset recalls the stored value
  p_recall_r8: assert property (@(posedge clk) disable iff (factory_rst)
    pwr_rst |=> wiper_pos == $past(stored));
endmodule

// File: tb/tb_wiper_ctrl.sv
module tb_wiper_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 16;
  localparam int WR   = 20;

  logic clk = 0;
  logic factory_rst_n = 0, pwr_rst_n = 0;
  logic sel_n = 1, dir_up = 0, step_n = 1;
  logic [TAPS-1:0] tap_sel;
  logic [3:0] wiper_pos;
  logic busy, standby;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_ctrl #(.TAPS(TAPS), .WRITE_CYCLES(WR)) dut (
    .clk(clk), .factory_rst_n(factory_rst_n), .pwr_rst_n(pwr_rst_n),
    .sel_n(sel_n), .dir_up(dir_up), .step_n(step_n),
    .tap_sel(tap_sel), .wiper_pos(wiper_pos), .busy(busy), .standby(standby)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit chk_on = 0;

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got=%0d exp=%0d", req, $time, got, exp);
    end
  endtask

  // Behavioural reference: pins seen after a two-sample latency queue.
  int m_pos = 8, m_nv = 8, m_cnt = 0, m_stby = 1;
  int lat_q[$];
  int m_prev = 3;  // {sel_n, step_n}
  localparam int IDLE = 6; // sel_n=1 step_n=1 dir=0 -> bits {sel,step,dir}

  always @(posedge clk) begin
    if (!factory_rst_n || !pwr_rst_n) begin
      if (!factory_rst_n) begin m_nv = 8; m_pos = 8; end
      else m_pos = m_nv;
      m_cnt = 0; m_stby = 1; m_prev = 3;
      lat_q = '{IDLE, IDLE};
    end else begin
      int s; bit s_sel, s_step, s_dir, p_sel, p_step, bz, act;
      s = lat_q.pop_front();
      s_sel = s[2]; s_step = s[1]; s_dir = s[0];
      p_sel = m_prev[1]; p_step = m_prev[0];
      bz = (m_cnt != 0);
      act = !bz && !s_sel;
      if (act && p_step && !s_step) begin
        if (s_dir && m_pos < TAPS-1) m_pos++;
        else if (!s_dir && m_pos > 0) m_pos--;
      end
      if (!bz && s_sel && !p_sel && s_step) begin
        m_nv = m_pos; m_cnt = WR;
      end else if (m_cnt != 0) begin
        if (m_cnt == 1) m_stby = 1;
        m_cnt--;
      end
      if (act) m_stby = 0;
      m_prev = {s_sel, s_step};
      lat_q.push_back({sel_n, step_n, dir_up});
    end
  end

  always @(negedge clk) if (chk_on) begin
    check({cur_req, " pos"}, wiper_pos, m_pos);
    check("R2 tap", tap_sel, 1 << m_pos);
    check({cur_req, " busy"}, busy, m_cnt != 0);
    check({cur_req, " standby"}, standby, m_stby);
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic step(bit up);
    dir_up = up; cyc(2); step_n = 0; cyc(4); step_n = 1; cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cur_req = "R1"; cyc(3); factory_rst_n = 1; pwr_rst_n = 1; chk_on = 1; cyc(1);
    check("R1 reset pos", wiper_pos, 8);
    check("R1 reset standby", standby, 1);
    check("R1 reset busy", busy, 0);
    check("R2 reset tap", tap_sel, 16'h0100);
    cur_req = "R10"; sel_n = 0; cyc(5);
    check("R10 standby cleared", standby, 0);
    cur_req = "R3"; for (int i = 0; i < 3; i++) step(1);
    check("R3 up x3", wiper_pos, 11);
    cur_req = "R11"; step(0);
    check("R11 reverse", wiper_pos, 10);
    cur_req = "R6"; sel_n = 1; cyc(4);
    check("R6 busy", busy, 1);
    cur_req = "R9"; sel_n = 0; cyc(2); step_n = 0; cyc(2); step_n = 1; cyc(2); sel_n = 1; cyc(2);
    check("R9 pos held", wiper_pos, 10);
    cur_req = "R6"; cyc(WR);
    check("R6 busy end", busy, 0);
    check("R10 standby after save", standby, 1);
    cur_req = "R8"; pwr_rst_n = 0; cyc(2); pwr_rst_n = 1; cyc(2);
    check("R8 recall", wiper_pos, 10);
    cur_req = "R5"; step(1); step(0); step(1);
    check("R5 ignored", wiper_pos, 10);
    cur_req = "R4"; sel_n = 0; cyc(4);
    for (int i = 0; i < 8; i++) step(1);
    check("R4 top", wiper_pos, 15);
    for (int i = 0; i < 18; i++) step(0);
    check("R4 bottom", wiper_pos, 0);
    cur_req = "R7"; dir_up = 0; step_n = 0; cyc(4); sel_n = 1; cyc(4); step_n = 1; cyc(6);
    check("R7 no busy", busy, 0);
    check("R7 live pos", wiper_pos, 0);
    pwr_rst_n = 0; cyc(2); pwr_rst_n = 1; cyc(2);
    check("R7 old value back", wiper_pos, 10);
    cur_req = "R1"; factory_rst_n = 0; cyc(2); factory_rst_n = 1; cyc(2);
    check("R1 factory", wiper_pos, 8);
    pwr_rst_n = 0; cyc(2); pwr_rst_n = 1; cyc(2);
    check("R1 factory stored", wiper_pos, 8);
    chk_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule